// File: doc/BRIEF.md
# Register-mapped SPI master controller

This block is a byte-wide SPI master that sits behind a small 16-bit register port. It has three registers: a data register, a control word and a status byte. Software sets up the control word: enable, clock phase, clock idle level and a 7-bit half-period divisor. It then writes a byte to the data register, and that write starts a full-duplex 8-bit exchange. Software polls the busy flag and then the receive-full flag, and reads the received byte back from the same data register. Chip select is not generated here; it is an external general-purpose output that software drives around the transfers.

The shift engine is a small state machine with three named states. `ST_IDLE` drives SCLK at its idle level and waits for a data write. `ST_LEAD` is the first half of a bit, with SCLK at its idle level. `ST_TRAIL` is the second half of a bit, with SCLK at the opposite level. The machine has five transitions:
- `ST_IDLE -> ST_LEAD` on an accepted data write.
- `ST_LEAD -> ST_TRAIL` on a half-period tick, which is the first SCLK edge.
- `ST_TRAIL -> ST_LEAD` on a tick when bits remain, which is the second SCLK edge.
- `ST_TRAIL -> ST_IDLE` on the tick that ends the eighth bit, which is completion.
- Any state `-> ST_IDLE` whenever the enable bit is low, which is the abort.

A divider counts D+1 bus clocks per half period and produces the ticks.

Top module: `spi_reg_master`

## Requirements
- R1: After reset the control word reads 0x0000, the status byte reads 0x00 and SCLK is low.
- R2: Registers are decoded as follows: offset 0 is data, offset 2 is control and offset 4 is status. Control fields are enable at bit 0, phase at bit 7, idle level at bit 8 and divisor D at bits 15:9. A control read returns the written value with bits 6:1 forced to zero. Reads at any other offset return zero.
- R3: A data write is accepted only when enable is 1 and busy is 0. Busy (status bit 0) is high from the next cycle for exactly 16×(D+1) cycles.
- R4: SCLK rests at the idle-level bit. Every half period lasts D+1 bus clocks. Each bit has one half at the idle level followed by one half at the opposite level.
- R5: Data moves MSB first. With phase 0, MOSI is valid before the first edge of each bit, MISO is sampled on the first edge and MOSI changes on the second edge. With phase 1, MOSI changes on the first edge and MISO is sampled on the second edge.
- R6: Receive-full (status bit 1) sets in the same cycle that busy falls. A data read then returns the byte shifted in from MISO.
- R7: A data read clears receive-full. If the read falls in the completion cycle, receive-full stays set and the read returns the previous byte.
- R8: A data write made while busy, or while enable is 0, is ignored: no transfer starts or restarts, and the byte in flight is unchanged.
- R9: Clearing enable forces SCLK to its idle level at once. Busy and receive-full read as 0 from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational on bus_addr |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Completion of a byte and a software read of the data register can land in the same bus cycle. The read wants to clear receive-full while completion wants to set it. The bench provokes this by starting a second transfer and counting exactly 16×(D+1) cycles, so that the data read strobe is high on the completion edge. It then expects three things: the read returns the earlier byte, the status still shows receive-full, and a second read returns the new byte. The cycle-level model also lines up a data write against completion and a disable against an active shift, and it compares SCLK, MOSI and status on every clock.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int DIV_W     = 7;
    localparam int EN_BIT    = 0;
    localparam int CPHA_BIT  = 7;
    localparam int CPOL_BIT  = 8;
    localparam int DIV_LSB   = 9;
    localparam int STAT_BUSY = 0;
    localparam int STAT_RBF  = 1;

    localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd4;

    localparam logic [REG_W-1:0] CTRL_MASK =
        (REG_W'(1) << EN_BIT) | (REG_W'(1) << CPHA_BIT) |
        (REG_W'(1) << CPOL_BIT) | (REG_W'((1 << DIV_W) - 1) << DIV_LSB);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LEAD,
        ST_TRAIL
    } eng_state_t;
endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              busy_i,
    input  logic              rbf_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    output logic              en_o,
    output logic              cpha_o,
    output logic              cpol_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              data_wr_o,
    output logic              data_rd_o,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic [REG_W-1:0]  rdata_o
);
    logic [REG_W-1:0] ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_i && addr_i == OFS_CTRL) begin
            ctrl_q <= wdata_i & CTRL_MASK;
        end
    end

    assign en_o      = ctrl_q[EN_BIT];
    assign cpha_o    = ctrl_q[CPHA_BIT];
    assign cpol_o    = ctrl_q[CPOL_BIT];
    assign div_o     = ctrl_q[DIV_LSB +: DIV_W];
    assign data_wr_o = wr_i && addr_i == OFS_DATA;
    assign data_rd_o = rd_i && addr_i == OFS_DATA;
    assign tx_byte_o = wdata_i[DATA_W-1:0];

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_DATA: rdata_o[DATA_W-1:0] = rx_byte_i;
            OFS_CTRL: rdata_o = ctrl_q;
            OFS_STAT: begin
                rdata_o[STAT_BUSY] = busy_i;
                rdata_o[STAT_RBF]  = rbf_i;
            end
            default:  rdata_o = '0;
        endcase
    end

    // R2
    ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_CTRL) |=> (en_o == $past(wdata_i[EN_BIT]) &&
                                          div_o == $past(wdata_i[DIV_LSB +: DIV_W])));
endmodule

// File: rtl/spi_rm_clkdiv.sv
module spi_rm_clkdiv
    import spi_rm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = run_i && cnt_q == div_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_o && $stable(div_i)) |=> (cnt_q == $past(cnt_q) + 1'b1 || !run_i));
endmodule

// File: rtl/spi_rm_engine.sv
module spi_rm_engine
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              cpha_i,
    input  logic              cpol_i,
    input  logic              tick_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              data_rd_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              rbf_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              sclk_o,
    output logic              mosi_o
);
    localparam int BIT_W = $clog2(DATA_W);

    eng_state_t        state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] tx_q, rx_q, rxbuf_q;
    logic              rbf_q;
    logic              last_bit, edge1, edge2, sample, launch, done;

    assign last_bit = bit_q == BIT_W'(DATA_W - 1);
    assign edge1    = en_i && state_q == ST_LEAD && tick_i;
    assign edge2    = en_i && state_q == ST_TRAIL && tick_i;
    assign sample   = cpha_i ? edge2 : edge1;
    assign launch   = cpha_i ? (edge1 && bit_q != '0) : edge2;
    assign done     = edge2 && last_bit;

    always_comb begin
        state_d = state_q;
        if (!en_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start_i) state_d = ST_LEAD;
                ST_LEAD:  if (tick_i)  state_d = ST_TRAIL;
                ST_TRAIL: if (tick_i)  state_d = last_bit ? ST_IDLE : ST_LEAD;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            tx_q    <= '0;
            rx_q    <= '0;
            rxbuf_q <= '0;
            rbf_q   <= 1'b0;
        end else begin
            if (!en_i) begin
                bit_q <= '0;
            end else if (state_q == ST_IDLE && start_i) begin
                bit_q <= '0;
                tx_q  <= tx_byte_i;
            end else begin
                if (launch) tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
                if (sample) rx_q  <= {rx_q[DATA_W-2:0], miso_i};
                if (edge2)  bit_q <= bit_q + 1'b1;
            end
            if (done) rxbuf_q <= cpha_i ? {rx_q[DATA_W-2:0], miso_i} : rx_q;
            if (!en_i)          rbf_q <= 1'b0;
            else if (done)      rbf_q <= 1'b1;
            else if (data_rd_i) rbf_q <= 1'b0;
        end
    end

    always_comb begin
        busy_o    = state_q != ST_IDLE;
        rbf_o     = rbf_q;
        rx_byte_o = rxbuf_q;
        sclk_o    = (en_i && state_q == ST_TRAIL) ? ~cpol_i : cpol_i;
        mosi_o    = tx_q[DATA_W-1];
    end

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && en_i && !busy_o) |=> busy_o);
    // R8
    ignore_busy_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && en_i && start_i && !tick_i) |=> bit_q == $past(bit_q));
    // R6
    rbf_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rbf_q) |-> ($past(busy_o) && !busy_o));
    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!busy_o && !rbf_q));
    // R4
    sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && busy_o && !tick_i) |=> ($stable(sclk_o) || !en_i || !$stable(cpol_i)));
endmodule

// File: rtl/spi_reg_master.sv
module spi_reg_master
    import spi_rm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);
    logic              en, cpha, cpol, data_wr, data_rd, busy, rbf, tick;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] tx_byte, rx_byte;

    spi_rm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .rd_i(bus_rd),
        .addr_i(bus_addr), .wdata_i(bus_wdata), .busy_i(busy), .rbf_i(rbf),
        .rx_byte_i(rx_byte), .en_o(en), .cpha_o(cpha), .cpol_o(cpol),
        .div_o(div), .data_wr_o(data_wr), .data_rd_o(data_rd),
        .tx_byte_o(tx_byte), .rdata_o(bus_rdata)
    );

    spi_rm_clkdiv u_div (
        .clk(clk), .rst_n(rst_n), .run_i(busy && en), .div_i(div), .tick_o(tick)
    );

    spi_rm_engine u_eng (
        .clk(clk), .rst_n(rst_n), .en_i(en), .cpha_i(cpha), .cpol_i(cpol),
        .tick_i(tick), .start_i(data_wr), .tx_byte_i(tx_byte),
        .data_rd_i(data_rd), .miso_i(spi_miso), .busy_o(busy), .rbf_o(rbf),
        .rx_byte_o(rx_byte), .sclk_o(spi_sclk), .mosi_o(spi_mosi)
    );
endmodule

// File: tb/test_spi_reg_master.sv
`timescale 1ns/1ps
module test_spi_reg_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = 3'd4;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    spi_reg_master i_spi_reg_master (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    // behavioural reference
    bit       m_en, m_cpha, m_cpol, m_active, m_rbf;
    int       m_div, m_p;
    bit [7:0] m_tx, m_rx, m_sl;
    bit [7:0] s_byte = 8'h00;

    function automatic int m_idx();
        int h = m_p / (m_div + 1);
        if (m_cpha) return (h == 0) ? 7 : 7 - (h - 1) / 2;
        return 7 - h / 2;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_cpha = 0; m_cpol = 0; m_div = 0;
            m_active = 0; m_rbf = 0; m_p = 0; m_rx = 0; m_tx = 0; m_sl = 0;
        end else begin
            if (!m_en) begin
                m_active = 0; m_rbf = 0;
            end else begin
                if (bus_rd && bus_addr == 3'd0) m_rbf = 0;
                if (m_active) begin
                    if (m_p == 16 * (m_div + 1) - 1) begin
                        m_active = 0; m_rbf = 1; m_rx = m_sl;
                    end else m_p++;
                end else if (bus_wr && bus_addr == 3'd0) begin
                    m_active = 1; m_p = 0; m_tx = bus_wdata[7:0]; m_sl = s_byte;
                end
            end
            if (bus_wr && bus_addr == 3'd2) begin
                m_en = bus_wdata[0]; m_cpha = bus_wdata[7];
                m_cpol = bus_wdata[8]; m_div = int'(bus_wdata[15:9]);
            end
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            bit exp_sclk;
            exp_sclk = (m_active && m_en && ((m_p / (m_div + 1)) % 2 == 1)) ? ~m_cpol : m_cpol;
            check(spi_sclk == exp_sclk, "R4 sclk", spi_sclk, exp_sclk);
            if (m_active && m_en)
                check(spi_mosi == m_tx[m_idx()], "R5 mosi", spi_mosi, m_tx[m_idx()]);
            if (bus_addr == 3'd4)
                check(bus_rdata == {14'b0, m_rbf, m_active}, "R3 status",
                      bus_rdata, {14'b0, m_rbf, m_active});
            spi_miso = m_active ? m_sl[m_idx()] : 1'b0;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0; bus_addr = 3'd4;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        #0.5 v = bus_rdata;
        @(negedge clk); bus_rd = 0; bus_addr = 3'd4;
    endtask

    function automatic logic [15:0] ctl(bit en, bit cpol, bit cpha, int d);
        return {7'(d), cpol, cpha, 6'b0, en};
    endfunction

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(3'd4, v);
            if (!v[0]) return;
        end
        check(0, "R3 busy stuck", 1, 0);
    endtask

    task automatic xfer(bit cpol, bit cpha, int d, logic [7:0] tx, logic [7:0] sl);
        logic [15:0] v;
        wr(3'd2, ctl(1, cpol, cpha, d));
        s_byte = sl;
        wr(3'd0, {8'h00, tx});
        rd(3'd4, v);
        check(v[0] == 1'b1, "R3 busy after start", v, 1);
        wait_idle();
        rd(3'd4, v);
        check(v == 16'h0002, "R6 rbf set", v, 2);
        rd(3'd0, v);
        check(v == {8'h00, sl}, "R6 rx byte", v, sl);
        rd(3'd4, v);
        check(v == 16'h0000, "R7 rbf cleared by read", v, 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(3'd2, v); check(v == 0, "R1 ctrl reset", v, 0);
        rd(3'd4, v); check(v == 0, "R1 status reset", v, 0);
        check(spi_sclk == 0, "R1 sclk low", spi_sclk, 0);
        // R2 masked control readback, unmapped offset
        wr(3'd2, 16'hFFFF);
        rd(3'd2, v); check(v == 16'hFF81, "R2 ctrl readback", v, 16'hFF81);
        rd(3'd6, v); check(v == 0, "R2 unmapped", v, 0);
        wr(3'd2, 16'h0000);
        // R3 R4 R5 R6 all four modes, several divisors
        xfer(0, 0, 0,   8'hA5, 8'h3C);
        xfer(0, 1, 1,   8'h81, 8'hE7);
        xfer(1, 0, 3,   8'h5A, 8'hC3);
        xfer(1, 1, 2,   8'h0F, 8'hF0);
        xfer(0, 0, 127, 8'h96, 8'h69);
        // R8 write while busy ignored
        wr(3'd2, ctl(1, 0, 0, 2));
        s_byte = 8'h55;
        wr(3'd0, 16'h00AA);
        repeat (10) @(negedge clk);
        s_byte = 8'h00;
        wr(3'd0, 16'h0011);
        wait_idle();
        rd(3'd0, v); check(v == 16'h0055, "R8 busy write ignored", v, 16'h55);
        // R8 write while disabled ignored
        wr(3'd2, ctl(0, 0, 0, 2));
        wr(3'd0, 16'h0077);
        rd(3'd4, v); check(v == 0, "R8 disabled write ignored", v, 0);
        wr(3'd2, ctl(1, 0, 0, 2));
        repeat (3) @(negedge clk);
        rd(3'd4, v); check(v == 0, "R8 no pending start", v, 0);
        // R9 abort mid transfer
        wr(3'd2, ctl(1, 1, 0, 3));
        s_byte = 8'h99;
        wr(3'd0, 16'h0033);
        repeat (20) @(negedge clk);
        wr(3'd2, ctl(0, 1, 0, 3));
        check(spi_sclk == 1, "R9 sclk idle after abort", spi_sclk, 1);
        rd(3'd4, v); check(v == 0, "R9 status after abort", v, 0);
        // R9 disable clears pending rbf
        wr(3'd2, ctl(1, 0, 1, 0));
        s_byte = 8'h42;
        wr(3'd0, 16'h0024);
        wait_idle();
        rd(3'd4, v); check(v == 2, "R6 rbf before disable", v, 2);
        wr(3'd2, ctl(0, 0, 1, 0));
        wr(3'd2, ctl(1, 0, 1, 0));
        rd(3'd4, v); check(v == 0, "R9 rbf cleared by disable", v, 0);
        // R7 data read on the completion cycle
        xfer(0, 0, 1, 8'h12, 8'h34);
        s_byte = 8'h78;
        wr(3'd0, 16'h0056);
        repeat (30) @(negedge clk);
        rd(3'd0, v); check(v == 16'h0034, "R7 coincident read old byte", v, 16'h34);
        rd(3'd4, v); check(v == 2, "R7 rbf kept on coincidence", v, 2);
        rd(3'd0, v); check(v == 16'h0078, "R7 new byte", v, 16'h78);
        rd(3'd4, v); check(v == 0, "R7 rbf cleared", v, 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule